// File: doc/BRIEF.md
# Error-Driven Clock Skew Level Tuner

This block is a small sequencer for a chip that detects late data at run time and can nudge the clock arrival time of each flip-flop group. It serves M groups. Each group has a 3-bit skew level from 1 to 5, and the five levels stand for evenly spaced clock offsets from the most negative offset to the most positive one. At the end of every tuning period, an outside agent pulses `start_i` and presents that period's error count for each group. It also presents a static receiver mask for each group. The engine keeps the previous period's counts and the current period's counts in registers. It then steps through the groups one per cycle, updates each group's level and its "still adjustable" flag, and pulses `done_o` when the new level vector is ready to be shifted out to the delay elements.

Tuning runs in two stages. In the first stage the engine pulls groups that saw no errors toward earlier levels, one step per period. A move is kept while the benefit does not go negative. The benefit of a group is the sum, over the group itself and every group it feeds, of the previous error count minus the current one. When no error-free group is still adjustable, the second stage starts. In every period of the second stage, the engine raises the adjustable group with the most errors by one step. In the next period it undoes that step and locks the group if the benefit turned negative.

Top module: `skew_tuner`

## Requirements
- R1: After reset, every level is 3, every adjustable flag is 0 and `done_o` is 0.
- R2: In the first period, each group with a zero error count has its level lowered by one and its flag set. Every other group keeps level 3 with its flag clear.
- R3: The benefit of group k is the signed sum of previous minus current error count over group k and every group j whose bit j is set in `adj_i[k*M +: M]`. Group k's own term is always included. A benefit of 0 or more counts as beneficial.
- R4: In a first-stage period, an adjustable group with a zero count and a beneficial benefit is lowered by one. If it is already at level 1, it is locked instead. If its benefit is negative, it is raised by one and locked. Groups with nonzero counts are left untouched.
- R5: When a first-stage period ends with no group that is both error-free and adjustable, the engine sets the flag of every group below level 5 and performs a second-stage selection within the same period.
- R6: A second-stage selection raises by one the adjustable group with the largest current count. A tie goes to the lowest index. A group that reaches level 5 is locked.
- R7: At the start of each later second-stage period, if the last raised group now has a negative benefit, it is lowered by one and locked before the next selection.
- R8: Once a selection finds no adjustable group, tuning halts and later periods leave all levels and flags unchanged.
- R9: `done_o` is a single-cycle pulse. Counting the edge that samples `start_i` as 1, it rises after M+2 edges for a period that stays in the first stage, 2M+3 edges for a period that enters the second stage, M+3 edges for a second-stage period and 1 edge once halted.
- R10: A start pulse that arrives while a period is being processed is ignored, and so are error inputs that change during processing.
- R11: Every level stays within 1 to 5 at all times. A level moves by at most one step per cycle, and only one group moves per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | End-of-period pulse; samples `err_i` |
| err_i | input | M*W | Error count per group, group g in bits [g*W +: W] |
| adj_i | input | M*M | Receiver mask, group g in bits [g*M +: M] |
| lvl_o | output | M*3 | Skew level per group, group g in bits [g*3 +: 3] |
| tunable_o | output | M | Adjustable flag per group |
| done_o | output | 1 | One-cycle pulse when the new levels are valid |

## Verification
The results of a period are due at a fixed number of edges after the edge that samples the start pulse: M+2, 2M+3, M+3 or 1 edges, depending on the stage the reference model is in. The bench counts edges from that sampling edge and samples at each falling edge. It requires `done_o` to be low before the predicted count, high exactly at that count and low again one cycle later. The bench compares levels and flags only after that point, while the engine is idle. It also confirms that the stray start pulses and changed error inputs it injects mid-period shift neither the latency nor the result.

// File: rtl/skew_tuner_pkg.sv
package skew_tuner_pkg;
    localparam int LVL_W = 3;
    localparam logic [LVL_W-1:0] LVL_LOW  = 3'd1;
    localparam logic [LVL_W-1:0] LVL_MID  = 3'd3;
    localparam logic [LVL_W-1:0] LVL_HIGH = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_CHECK,
        ST_REVERT,
        ST_SELECT,
        ST_APPLY,
        ST_DONE
    } tuner_state_e;

    typedef enum logic [1:0] {
        PH_FIRST,
        PH_DRAIN,
        PH_RAISE,
        PH_HALT
    } tuner_phase_e;
endpackage

// File: rtl/skew_benefit_unit.sv
module skew_benefit_unit #(
    parameter int M  = 6,
    parameter int W  = 8,
    parameter int IW = 3,
    parameter int BW = 12
) (
    input  logic [M*W-1:0]        prev_i,
    input  logic [M*W-1:0]        cur_i,
    input  logic [M-1:0]          mask_i,
    input  logic [IW-1:0]         self_i,
    output logic signed [BW-1:0]  benefit_o
);
    localparam int PAD = BW - W;

    always_comb begin
        logic signed [BW-1:0] acc;
        acc = '0;
        for (int j = 0; j < M; j++) begin
            if (mask_i[j] || (j == int'(self_i))) begin
                acc = acc + ($signed({{PAD{1'b0}}, prev_i[j*W +: W]})
                           - $signed({{PAD{1'b0}}, cur_i[j*W +: W]}));
            end
        end
        benefit_o = acc;
    end
endmodule

// File: rtl/skew_step_unit.sv
module skew_step_unit
    import skew_tuner_pkg::*;
(
    input  logic             first_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             tun_i,
    input  logic             zero_i,
    input  logic             neg_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic             tun_o
);
    always_comb begin
        lvl_o = lvl_i;
        tun_o = tun_i;
        if (first_i) begin
            if (zero_i && (lvl_i != LVL_LOW)) begin
                lvl_o = lvl_i - 3'd1;
                tun_o = 1'b1;
            end
        end else if (zero_i && tun_i) begin
            if (!neg_i) begin
                if (lvl_i != LVL_LOW) begin
                    lvl_o = lvl_i - 3'd1;
                end else begin
                    tun_o = 1'b0;
                end
            end else begin
                lvl_o = lvl_i + 3'd1;
                tun_o = 1'b0;
            end
        end
    end
endmodule

// File: rtl/skew_tuner.sv
module skew_tuner
    import skew_tuner_pkg::*;
#(
    parameter int M = 6,
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [M*W-1:0]   err_i,
    input  logic [M*M-1:0]   adj_i,
    output logic [M*3-1:0]   lvl_o,
    output logic [M-1:0]     tunable_o,
    output logic             done_o
);
    localparam int IW = (M > 1) ? $clog2(M) : 1;
    localparam int BW = W + $clog2(M) + 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(M - 1);

    typedef struct packed {
        tuner_state_e              st;
        tuner_phase_e              ph;
        logic [IW-1:0]             idx;
        logic [IW-1:0]             best;
        logic                      best_ok;
        logic [W-1:0]              best_err;
        logic [IW-1:0]             last;
        logic                      last_ok;
        logic [M-1:0][LVL_W-1:0]   lvl;
        logic [M-1:0]              tun;
        logic [M-1:0][W-1:0]       ecur;
        logic [M-1:0][W-1:0]       eprev;
    } regs_t;

    regs_t r_q, r_d;

    logic [IW-1:0]         bidx;
    logic [M-1:0]          bmask;
    logic signed [BW-1:0]  benefit;
    logic                  ben_neg;
    logic [M-1:0]          zero_vec;
    logic                  zero_tunable;
    logic [LVL_W-1:0]      step_lvl;
    logic                  step_tun;
    logic                  idle_w;

    assign idle_w = (r_q.st == ST_IDLE);

    always_comb begin
        bidx  = (r_q.st == ST_REVERT) ? r_q.last : r_q.idx;
        bmask = adj_i[int'(bidx)*M +: M];
        for (int g = 0; g < M; g++) begin
            zero_vec[g] = (r_q.ecur[g] == '0);
        end
        zero_tunable = |(zero_vec & r_q.tun);
    end

    skew_benefit_unit #(.M(M), .W(W), .IW(IW), .BW(BW)) u_benefit (
        .prev_i    (r_q.eprev),
        .cur_i     (r_q.ecur),
        .mask_i    (bmask),
        .self_i    (bidx),
        .benefit_o (benefit)
    );

    assign ben_neg = (benefit < 0);

    skew_step_unit u_step (
        .first_i (r_q.ph == PH_FIRST),
        .lvl_i   (r_q.lvl[r_q.idx]),
        .tun_i   (r_q.tun[r_q.idx]),
        .zero_i  (zero_vec[r_q.idx]),
        .neg_i   (ben_neg),
        .lvl_o   (step_lvl),
        .tun_o   (step_tun)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.eprev = r_q.ecur;
                    for (int g = 0; g < M; g++) begin
                        r_d.ecur[g] = err_i[g*W +: W];
                    end
                    r_d.idx = '0;
                    unique case (r_q.ph)
                        PH_FIRST, PH_DRAIN: r_d.st = ST_SCAN;
                        PH_RAISE:           r_d.st = ST_REVERT;
                        default:            r_d.st = ST_DONE;
                    endcase
                end
            end
            ST_SCAN: begin
                r_d.lvl[r_q.idx] = step_lvl;
                r_d.tun[r_q.idx] = step_tun;
                if (r_q.idx == LAST_IDX) begin
                    r_d.st = ST_CHECK;
                end else begin
                    r_d.idx = r_q.idx + IW'(1);
                end
            end
            ST_CHECK: begin
                if (zero_tunable) begin
                    r_d.ph = PH_DRAIN;
                    r_d.st = ST_DONE;
                end else begin
                    r_d.ph = PH_RAISE;
                    for (int g = 0; g < M; g++) begin
                        r_d.tun[g] = (r_q.lvl[g] != LVL_HIGH);
                    end
                    r_d.idx     = '0;
                    r_d.best_ok = 1'b0;
                    r_d.st      = ST_SELECT;
                end
            end
            ST_REVERT: begin
                if (r_q.last_ok && ben_neg) begin
                    r_d.lvl[r_q.last] = r_q.lvl[r_q.last] - 3'd1;
                    r_d.tun[r_q.last] = 1'b0;
                end
                r_d.idx     = '0;
                r_d.best_ok = 1'b0;
                r_d.st      = ST_SELECT;
            end
            ST_SELECT: begin
                if (r_q.tun[r_q.idx] &&
                    (!r_q.best_ok || (r_q.ecur[r_q.idx] > r_q.best_err))) begin
                    r_d.best     = r_q.idx;
                    r_d.best_err = r_q.ecur[r_q.idx];
                    r_d.best_ok  = 1'b1;
                end
                if (r_q.idx == LAST_IDX) begin
                    r_d.st = ST_APPLY;
                end else begin
                    r_d.idx = r_q.idx + IW'(1);
                end
            end
            ST_APPLY: begin
                if (r_q.best_ok) begin
                    r_d.lvl[r_q.best] = r_q.lvl[r_q.best] + 3'd1;
                    if (r_q.lvl[r_q.best] == (LVL_HIGH - 3'd1)) begin
                        r_d.tun[r_q.best] = 1'b0;
                    end
                    r_d.last    = r_q.best;
                    r_d.last_ok = 1'b1;
                end else begin
                    r_d.ph = PH_HALT;
                end
                r_d.st = ST_DONE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.ph       <= PH_FIRST;
            r_q.idx      <= '0;
            r_q.best     <= '0;
            r_q.best_ok  <= 1'b0;
            r_q.best_err <= '0;
            r_q.last     <= '0;
            r_q.last_ok  <= 1'b0;
            r_q.tun      <= '0;
            r_q.ecur     <= '0;
            r_q.eprev    <= '0;
            for (int g = 0; g < M; g++) begin
                r_q.lvl[g] <= LVL_MID;
            end
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        for (int g = 0; g < M; g++) begin
            lvl_o[g*3 +: 3] = r_q.lvl[g];
        end
    end

    assign tunable_o = r_q.tun;
    assign done_o    = (r_q.st == ST_DONE);
endmodule

// File: rtl/skew_tuner_chk.sv
module skew_tuner_chk #(
    parameter int M = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start_i,
    input logic           idle_i,
    input logic [M*3-1:0] lvl_i,
    input logic [M-1:0]   tun_i,
    input logic           done_i
);
    logic [M*3-1:0] lvl_prev_q;
    logic [M-1:0]   moved;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_prev_q <= {M{3'd3}};
        end else begin
            lvl_prev_q <= lvl_i;
        end
    end

    always_comb begin
        for (int g = 0; g < M; g++) begin
            moved[g] = (lvl_i[g*3 +: 3] != lvl_prev_q[g*3 +: 3]);
        end
    end

    assert_one_mover_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(moved) <= 1);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !done_i);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_i && !start_i) |=> ($stable(lvl_i) && $stable(tun_i)));

    for (genvar g = 0; g < M; g++) begin : g_grp
        assert_lvl_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_i[g*3 +: 3] >= 3'd1) && (lvl_i[g*3 +: 3] <= 3'd5));

        assert_unit_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
            moved[g] |-> ((lvl_i[g*3 +: 3] == lvl_prev_q[g*3 +: 3] + 3'd1) ||
                          (lvl_i[g*3 +: 3] == lvl_prev_q[g*3 +: 3] - 3'd1)));

        assert_top_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
            !(tun_i[g] && (lvl_i[g*3 +: 3] == 3'd5)));
    end
endmodule

bind skew_tuner skew_tuner_chk #(.M(M)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .idle_i  (idle_w),
    .lvl_i   (lvl_o),
    .tun_i   (tunable_o),
    .done_i  (done_o)
);

// File: tb/tb_skew_tuner.sv
module tb_skew_tuner;
    localparam int M = 6;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [M*W-1:0] err = '0;
    logic [M*M-1:0] adj = '0;
    logic [M*3-1:0] lvl;
    logic [M-1:0]   tun;
    logic           done;

    always #(CLK_PERIOD/2) clk = ~clk;

    skew_tuner #(.M(M), .W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .err_i(err), .adj_i(adj),
        .lvl_o(lvl), .tunable_o(tun), .done_o(done)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    int mlvl[M];
    int mtun[M];
    int mcur[M];
    int mprev[M];
    int pe[M];
    int mph;
    int mlast;
    bit mlast_ok;
    bit madj[M][M];

    function automatic int ben(int k);
        int s = 0;
        for (int j = 0; j < M; j++)
            if (j == k || madj[k][j]) s += mprev[j] - mcur[j];
        return s;
    endfunction

    task automatic pick_raise();
        int best = -1;
        for (int i = 0; i < M; i++)
            if (mtun[i] != 0 && (best < 0 || mcur[i] > mcur[best])) best = i;
        if (best >= 0) begin
            mlvl[best]++;
            if (mlvl[best] == 5) mtun[best] = 0;
            mlast = best;
            mlast_ok = 1;
        end else begin
            mph = 3;
        end
    endtask

    task automatic model_period(output int lat, output string tag);
        bit any;
        for (int i = 0; i < M; i++) begin
            mprev[i] = mcur[i];
            mcur[i] = pe[i];
        end
        if (mph == 0 || mph == 1) begin
            tag = (mph == 0) ? "R2" : "R4";
            for (int i = 0; i < M; i++) begin
                if (mph == 0) begin
                    if (mcur[i] == 0) begin mtun[i] = 1; mlvl[i]--; end
                end else if (mcur[i] == 0 && mtun[i] != 0) begin
                    if (ben(i) >= 0) begin
                        if (mlvl[i] != 1) mlvl[i]--; else mtun[i] = 0;
                    end else begin
                        mlvl[i]++; mtun[i] = 0;
                    end
                end
            end
            any = 0;
            for (int i = 0; i < M; i++) if (mcur[i] == 0 && mtun[i] != 0) any = 1;
            if (any) begin
                mph = 1; lat = M + 2;
            end else begin
                tag = "R5";
                mph = 2;
                for (int i = 0; i < M; i++) mtun[i] = (mlvl[i] != 5) ? 1 : 0;
                pick_raise();
                lat = 2*M + 3;
            end
        end else if (mph == 2) begin
            tag = "R7";
            if (mlast_ok && ben(mlast) < 0) begin
                mlvl[mlast]--; mtun[mlast] = 0;
            end
            pick_raise();
            lat = M + 3;
        end else begin
            tag = "R8";
            lat = 1;
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s got %h exp %h", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = 1'b0;
        for (int i = 0; i < M; i++) begin
            mlvl[i] = 3; mtun[i] = 0; mcur[i] = 0; mprev[i] = 0;
        end
        mph = 0; mlast = 0; mlast_ok = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic compare_state(input string tag);
        logic [M*3-1:0] el;
        logic [M-1:0] et;
        bit inrange = 1;
        for (int i = 0; i < M; i++) begin
            el[i*3 +: 3] = 3'(mlvl[i]);
            et[i] = (mtun[i] != 0);
            if (lvl[i*3 +: 3] < 3'd1 || lvl[i*3 +: 3] > 3'd5) inrange = 0;
        end
        check(lvl == el, tag, "levels R3", 64'(lvl), 64'(el));
        check(tun == et, tag, "tunable flags", 64'(tun), 64'(et));
        check(inrange, "R11", "level range", 64'(lvl), 64'(el));
    endtask

    task automatic run_period(input bit disturb);
        int lat;
        int n;
        string tag;
        logic [M*W-1:0] ev;
        for (int g = 0; g < M; g++) ev[g*W +: W] = W'(pe[g]);
        model_period(lat, tag);
        err = ev;
        start = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) err = ~ev;
        while (!done && n < 300) begin
            start = (disturb && n == 2 && lat > 2);
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        start = 1'b0;
        check(n == lat, disturb ? "R10" : "R9", "done latency", 64'(n), 64'(lat));
        @(negedge clk);
        check(done == 1'b0, "R9", "done single pulse", 64'(done), 64'd0);
        compare_state(tag);
    endtask

    initial begin
        for (int k = 0; k < M; k++)
            for (int j = 0; j < M; j++) madj[k][j] = 0;
        madj[0][1] = 1; madj[1][2] = 1; madj[3][4] = 1;
        madj[3][5] = 1; madj[5][0] = 1; madj[2][3] = 1;
        for (int k = 0; k < M; k++)
            for (int j = 0; j < M; j++) adj[k*M + j] = madj[k][j];

        do_reset();
        check(lvl == {M{3'd3}}, "R1", "reset levels", 64'(lvl), 64'({M{3'd3}}));
        check(tun == '0, "R1", "reset flags", 64'(tun), 64'd0);
        check(done == 1'b0, "R1", "reset done", 64'(done), 64'd0);

        for (int i = 0; i < M; i++) pe[i] = 0;
        for (int p = 1; p <= 32; p++) begin
            run_period(1'b0);
            if (p == 3)
                check(lvl == 18'b001_001_001_001_001_010, "R6", "tie to lowest index",
                      64'(lvl), 64'(18'b001_001_001_001_001_010));
        end
        check(lvl == {M{3'd5}}, "R8", "halted all top", 64'(lvl), 64'({M{3'd5}}));
        check(tun == '0, "R8", "halted flags", 64'(tun), 64'd0);

        do_reset();
        pe[0] = 0; pe[1] = 4; pe[2] = 0; pe[3] = 2; pe[4] = 0; pe[5] = 6;
        run_period(1'b0);
        check(lvl == {3'd3, 3'd2, 3'd3, 3'd2, 3'd3, 3'd2}, "R2", "first period levels",
              64'(lvl), 64'({3'd3, 3'd2, 3'd3, 3'd2, 3'd3, 3'd2}));
        check(tun == 6'b010101, "R2", "first period flags", 64'(tun), 64'(6'b010101));
        for (int p = 0; p < 30; p++) begin
            for (int i = 0; i < M; i++)
                pe[i] = ($urandom % 3 == 0) ? 0 : int'($urandom % 40);
            run_period(p % 4 == 1);
        end

        for (int run = 0; run < 3; run++) begin
            do_reset();
            for (int p = 0; p < 40; p++) begin
                for (int i = 0; i < M; i++)
                    pe[i] = ($urandom % 2 == 0) ? 0 : int'($urandom % 250);
                run_period(p % 3 == 2);
            end
        end

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            miscompares++;
            vectors++;
            $display("FAIL watchdog run did not complete got 0 exp 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule